// File: doc/BRIEF.md
# Semi-SIMD Image Processing Element Array

A linear row of image-processing elements that all obey the same broadcast microinstruction on every clock. Each element holds a 16-bit datapath with four scratchpad registers, an 8-bit transfer register linked one way to its neighbour, a 3x3 pixel window, a condition flag and a small private memory. Three kinds of local autonomy are allowed under the shared control: each element can form its own memory address, choose which window position it reads, and cancel most of an instruction when its condition flag is clear.

Pixels arrive as three rows (above, current, below). Each element latches its own column of those rows. Its left and right window columns come from the adjacent elements. The wrapper connects the elements and exposes one selectable scratchpad register, the condition flag and the transfer register of every element.

Top module: `simd_pe_array`

## Requirements
- R1: After reset every scratchpad register, condition flag and transfer register reads zero, and the window direction is the centre (4).
- R2: With op_kind 1 the element writes ALU(A,B) to register dst, where A is register src_a. The alu_op codes are 0 add, 1 subtract A-B, 2 AND, 3 OR, 4 XOR, 5 pass A, 6 pass B and 7 pass A. All results wrap at 16 bits.
- R3: op_kind 3 loads the transfer register with A[7:0]. op_kind 4 moves every transfer register one element up in index, and element 0 receives zero.
- R4: The src_b codes are 0-3 scratchpad register, 4 the zero-extended window pixel, 5 bcast, 6 the memory word at the element's address, and 7 the zero-extended transfer register.
- R5: op_kind 2 sets the condition flag. alu_op[0]=0 takes bit 15 of the last executed ALU result and alu_op[0]=1 takes its zero test. Nothing else changes the flag, and only executed ALU operations change the stored sign and zero.
- R6: When cond_en=1 and the element's flag is clear, op_kind 1, 3, 5, 6 and 7 have no effect in that element. op_kind 2 and 4 still act.
- R7: op_kind 5 latches the element's own column from row_top, row_mid and row_bot. Window position p = 3*row + col, with row 0 top, 1 middle, 2 bottom and col 0 left element, 1 own, 2 right element.
- R8: op_kind 6 loads the element's direction from A[3:0], and a value above 8 becomes 4. Elements may hold different directions at once.
- R9: The first and last elements read zero for window columns that lie past the array end.
- R10: The 8-bit memory address for addr_mode 0 is bcast[7:0]. For mode 1 it is {bcast[7:4], r3[3:0]}, and for modes 2 and 3 it is r3[7:0]. op_kind 7 writes A to that address.
- R11: With cond_en=0 every operation executes whatever the flag holds. op_kind 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 3 | Instruction class |
| alu_op | input | 3 | ALU operation, or flag source for op_kind 2 |
| cond_en | input | 1 | Make this instruction conditional on each element's flag |
| src_a | input | 2 | Register used as operand A |
| src_b | input | 3 | Operand B select |
| dst | input | 2 | Destination register |
| addr_mode | input | 2 | Memory address mode |
| bcast | input | 16 | Broadcast constant and global address |
| row_top | input | 32 | Pixel row above, one byte per element |
| row_mid | input | 32 | Current pixel row, one byte per element |
| row_bot | input | 32 | Pixel row below, one byte per element |
| obs_sel | input | 2 | Register shown on obs_data |
| obs_data | output | 64 | Selected register of every element, 16 bits each |
| cond_out | output | 4 | Condition flag of every element |
| d_out | output | 32 | Transfer register of every element |

## Verification
The assertions assume op_kind, src_b and alu_op are driven to known values on every cycle after reset. They also assume that no memory word is read before it has been written. The stimulus keeps to this by filling all 256 words of every element's memory in global mode before any random traffic. After that it draws every field from the full range of its code space, so the illegal direction codes and the reserved ALU code are covered. Inputs change only well away from the rising edge. All rows are redrawn each cycle, so a latch that fires when it should not is visible through the window pixel.

// File: rtl/pe_pkg.sv
package pe_pkg;
    typedef enum logic [2:0] {
        K_NOP    = 3'd0,
        K_ALU    = 3'd1,
        K_LDCOND = 3'd2,
        K_DLOAD  = 3'd3,
        K_DSHIFT = 3'd4,
        K_NBLOAD = 3'd5,
        K_SETDIR = 3'd6,
        K_RAMWR  = 3'd7
    } kind_e;

    typedef enum logic [2:0] {
        A_ADD  = 3'd0,
        A_SUB  = 3'd1,
        A_AND  = 3'd2,
        A_OR   = 3'd3,
        A_XOR  = 3'd4,
        A_PASA = 3'd5,
        A_PASB = 3'd6,
        A_RSV  = 3'd7
    } aluop_e;

    localparam logic [2:0] B_WIN   = 3'd4;
    localparam logic [2:0] B_CONST = 3'd5;
    localparam logic [2:0] B_MEM   = 3'd6;
    localparam logic [2:0] B_XFER  = 3'd7;

    localparam int WIN_CELLS  = 9;
    localparam int WIN_CENTRE = 4;
endpackage

// File: rtl/pe_alu.sv
module pe_alu #(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    import pe_pkg::*;

    always_comb begin
        case (aluop_e'(op))
            A_ADD:   y = a + b;
            A_SUB:   y = a - b;
            A_AND:   y = a & b;
            A_OR:    y = a | b;
            A_XOR:   y = a ^ b;
            A_PASB:  y = b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/pe_addr_gen.sv
module pe_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] glob,
    input  logic [ADDR_W-1:0] loc,
    output logic [ADDR_W-1:0] addr
);
    localparam int HALF = ADDR_W / 2;

    always_comb begin
        case (mode)
            2'd0:    addr = glob;
            2'd1:    addr = {glob[ADDR_W-1:HALF], loc[HALF-1:0]};
            default: addr = loc;
        endcase
    end
endmodule

// File: rtl/pe_win_sel.sv
module pe_win_sel #(
    parameter int PIX_W = 8
) (
    input  logic [pe_pkg::WIN_CELLS-1:0][PIX_W-1:0] win,
    input  logic [3:0]                              dir,
    output logic [PIX_W-1:0]                        pix
);
    always_comb begin
        if (int'(dir) < pe_pkg::WIN_CELLS) pix = win[dir];
        else                               pix = win[pe_pkg::WIN_CENTRE];
    end
endmodule

// File: rtl/simd_pe.sv
module simd_pe #(
    parameter int DATA_W = 16,
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  op_kind,
    input  logic [2:0]                  alu_op,
    input  logic                        cond_en,
    input  logic [1:0]                  src_a,
    input  logic [2:0]                  src_b,
    input  logic [1:0]                  dst,
    input  logic [1:0]                  addr_mode,
    input  logic [DATA_W-1:0]           bcast,
    input  logic [2:0][PIX_W-1:0]       col_in,
    input  logic [2:0][PIX_W-1:0]       left_col,
    input  logic [2:0][PIX_W-1:0]       right_col,
    input  logic [PIX_W-1:0]            d_left,
    output logic [2:0][PIX_W-1:0]       col_out,
    output logic [PIX_W-1:0]            d_out,
    input  logic [1:0]                  obs_sel,
    output logic [DATA_W-1:0]           obs_data,
    output logic                        cond_out
);
    import pe_pkg::*;

    localparam int RAM_DEPTH = 1 << ADDR_W;
    localparam int NREG      = 4;
    localparam logic [3:0] DIR_MAX = 4'(WIN_CELLS - 1);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] rf;
        logic                        cond;
        logic                        sgn;
        logic                        zro;
        logic [PIX_W-1:0]            d;
        logic [3:0]                  dir;
        logic [2:0][PIX_W-1:0]       cols;
    } pe_state_t;

    pe_state_t s_d, s_q;

    logic [DATA_W-1:0] mem_q [RAM_DEPTH];
    logic [DATA_W-1:0] opa, opb, alu_y, mem_rd;
    logic [ADDR_W-1:0] addr;
    logic [PIX_W-1:0]  pix;
    logic [WIN_CELLS-1:0][PIX_W-1:0] win;
    logic              exec, mem_we;
    kind_e             kind;

    assign kind = kind_e'(op_kind);

    always_comb begin
        for (int r = 0; r < 3; r++) begin
            win[3*r+0] = left_col[r];
            win[3*r+1] = s_q.cols[r];
            win[3*r+2] = right_col[r];
        end
    end

    pe_win_sel #(.PIX_W(PIX_W)) u_win (.win(win), .dir(s_q.dir), .pix(pix));

    pe_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .mode(addr_mode), .glob(bcast[ADDR_W-1:0]),
        .loc(s_q.rf[3][ADDR_W-1:0]), .addr(addr)
    );

    assign mem_rd = mem_q[addr];
    assign opa    = s_q.rf[src_a];

    always_comb begin
        case (src_b)
            B_WIN:   opb = DATA_W'(pix);
            B_CONST: opb = bcast;
            B_MEM:   opb = mem_rd;
            B_XFER:  opb = DATA_W'(s_q.d);
            default: opb = s_q.rf[src_b[1:0]];
        endcase
    end

    pe_alu #(.DATA_W(DATA_W)) u_alu (.op(alu_op), .a(opa), .b(opb), .y(alu_y));

    always_comb begin
        s_d    = s_q;
        exec   = !(cond_en && !s_q.cond);
        mem_we = 1'b0;
        case (kind)
            K_ALU: if (exec) begin
                s_d.rf[dst] = alu_y;
                s_d.sgn     = alu_y[DATA_W-1];
                s_d.zro     = (alu_y == '0);
            end
            K_LDCOND: s_d.cond = alu_op[0] ? s_q.zro : s_q.sgn;
            K_DLOAD:  if (exec) s_d.d = opa[PIX_W-1:0];
            K_DSHIFT: s_d.d = d_left;
            K_NBLOAD: if (exec) s_d.cols = col_in;
            K_SETDIR: if (exec) s_d.dir = (opa[3:0] > DIR_MAX) ? 4'(WIN_CENTRE) : opa[3:0];
            K_RAMWR:  mem_we = exec;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.dir <= 4'(WIN_CENTRE);
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[addr] <= opa;
    end

    assign col_out  = s_q.cols;
    assign d_out    = s_q.d;
    assign obs_data = s_q.rf[obs_sel];
    assign cond_out = s_q.cond;

    // R6: a cancelled ALU instruction leaves registers and result flags alone
    a_r6_gated_alu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_ALU && cond_en && !s_q.cond) |=> ($stable(s_q.rf) && $stable(s_q.sgn) && $stable(s_q.zro)));

    // R5: only the flag-load instruction moves the condition flag
    a_r5_flag_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != K_LDCOND) |=> $stable(s_q.cond));

    // R3: a shift step takes the left neighbour's value
    a_r3_shift_takes_left: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_DSHIFT) |=> (s_q.d == $past(d_left)));

    // R8: direction never leaves the window
    a_r8_dir_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dir <= DIR_MAX);

    // R7: window columns change only on a latch instruction
    a_r7_cols_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != K_NBLOAD) |=> $stable(s_q.cols));
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array #(
    parameter int NUM_PE = 4,
    parameter int DATA_W = 16,
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 op_kind,
    input  logic [2:0]                 alu_op,
    input  logic                       cond_en,
    input  logic [1:0]                 src_a,
    input  logic [2:0]                 src_b,
    input  logic [1:0]                 dst,
    input  logic [1:0]                 addr_mode,
    input  logic [DATA_W-1:0]          bcast,
    input  logic [NUM_PE*PIX_W-1:0]    row_top,
    input  logic [NUM_PE*PIX_W-1:0]    row_mid,
    input  logic [NUM_PE*PIX_W-1:0]    row_bot,
    input  logic [1:0]                 obs_sel,
    output logic [NUM_PE*DATA_W-1:0]   obs_data,
    output logic [NUM_PE-1:0]          cond_out,
    output logic [NUM_PE*PIX_W-1:0]    d_out
);
    logic [NUM_PE-1:0][2:0][PIX_W-1:0] col_w;
    logic [NUM_PE-1:0][PIX_W-1:0]      d_w;

    for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
        logic [2:0][PIX_W-1:0] col_in, lcol, rcol;
        logic [PIX_W-1:0]      dl;

        assign col_in[0] = row_top[i*PIX_W +: PIX_W];
        assign col_in[1] = row_mid[i*PIX_W +: PIX_W];
        assign col_in[2] = row_bot[i*PIX_W +: PIX_W];

        if (i == 0) begin : g_first
            assign lcol = '0;
            assign dl   = '0;
        end else begin : g_inner_l
            assign lcol = col_w[i-1];
            assign dl   = d_w[i-1];
        end

        if (i == NUM_PE-1) begin : g_last
            assign rcol = '0;
        end else begin : g_inner_r
            assign rcol = col_w[i+1];
        end

        simd_pe #(.DATA_W(DATA_W), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_pe (
            .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .alu_op(alu_op),
            .cond_en(cond_en), .src_a(src_a), .src_b(src_b), .dst(dst),
            .addr_mode(addr_mode), .bcast(bcast), .col_in(col_in),
            .left_col(lcol), .right_col(rcol), .d_left(dl),
            .col_out(col_w[i]), .d_out(d_w[i]), .obs_sel(obs_sel),
            .obs_data(obs_data[i*DATA_W +: DATA_W]), .cond_out(cond_out[i])
        );

        assign d_out[i*PIX_W +: PIX_W] = d_w[i];
    end
endmodule

// File: tb/simd_pe_array_tb.sv
`timescale 1ns/1ps
module simd_pe_array_tb;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] op_kind = '0, alu_op = '0, src_b = '0;
    logic cond_en = 1'b0;
    logic [1:0] src_a = '0, dst = '0, addr_mode = '0, obs_sel = '0;
    logic [15:0] bcast = '0;
    logic [N*8-1:0] row_top = '0, row_mid = '0, row_bot = '0;
    logic [N*16-1:0] obs_data;
    logic [N-1:0] cond_out;
    logic [N*8-1:0] d_out;

    always #2.5 clk = ~clk;

    simd_pe_array #(.NUM_PE(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .alu_op(alu_op),
        .cond_en(cond_en), .src_a(src_a), .src_b(src_b), .dst(dst),
        .addr_mode(addr_mode), .bcast(bcast), .row_top(row_top),
        .row_mid(row_mid), .row_bot(row_bot), .obs_sel(obs_sel),
        .obs_data(obs_data), .cond_out(cond_out), .d_out(d_out)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    logic [15:0] m_rf [N][4];
    logic        m_cond [N], m_sgn [N], m_zro [N];
    logic [7:0]  m_d [N];
    logic [3:0]  m_dir [N];
    logic [7:0]  m_col [N][3];
    logic [15:0] m_mem [N][256];

    function automatic logic [15:0] f_alu(input logic [2:0] op, input logic [15:0] a, b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd6: return b;
            default: return a;
        endcase
    endfunction

    function automatic logic [7:0] f_pix(input int i);
        int p, r, c, j;
        p = int'(m_dir[i]);
        r = p / 3; c = p % 3; j = i + c - 1;
        if (j < 0 || j >= N) return 8'h00;
        return m_col[j][r];
    endfunction

    function automatic logic [7:0] f_addr(input int i, input logic [1:0] am, input logic [15:0] bc);
        case (am)
            2'd0: return bc[7:0];
            2'd1: return {bc[7:4], m_rf[i][3][3:0]};
            default: return m_rf[i][3][7:0];
        endcase
    endfunction

    function automatic logic [15:0] f_opb(input int i);
        case (src_b)
            3'd4: return {8'h00, f_pix(i)};
            3'd5: return bcast;
            3'd6: return m_mem[i][f_addr(i, addr_mode, bcast)];
            3'd7: return {8'h00, m_d[i]};
            default: return m_rf[i][src_b[1:0]];
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            for (int r = 0; r < 4; r++) m_rf[i][r] = '0;
            m_cond[i] = 0; m_sgn[i] = 0; m_zro[i] = 0; m_d[i] = '0; m_dir[i] = 4'd4;
            for (int r = 0; r < 3; r++) m_col[i][r] = '0;
        end
    endtask

    task automatic model_step();
        for (int i = N-1; i >= 0; i--) begin
            logic ex;
            logic [15:0] a, y;
            ex = !(cond_en && !m_cond[i]);
            a  = m_rf[i][src_a];
            case (op_kind)
                3'd1: if (ex) begin
                    y = f_alu(alu_op, a, f_opb(i));
                    m_rf[i][dst] = y; m_sgn[i] = y[15]; m_zro[i] = (y == 0);
                end
                3'd2: m_cond[i] = alu_op[0] ? m_zro[i] : m_sgn[i];
                3'd3: if (ex) m_d[i] = a[7:0];
                3'd4: m_d[i] = (i == 0) ? 8'h00 : m_d[i-1];
                3'd5: if (ex) begin
                    m_col[i][0] = row_top[i*8 +: 8];
                    m_col[i][1] = row_mid[i*8 +: 8];
                    m_col[i][2] = row_bot[i*8 +: 8];
                end
                3'd6: if (ex) m_dir[i] = (a[3:0] > 4'd8) ? 4'd4 : a[3:0];
                3'd7: if (ex) m_mem[i][f_addr(i, addr_mode, bcast)] = a;
                default: ;
            endcase
        end
    endtask

    task automatic check(input string tag, input string what, input logic [15:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        for (int s = 0; s < 4; s++) begin
            obs_sel = 2'(s);
            #0.2;
            for (int i = 0; i < N; i++)
                check(tag, $sformatf("pe%0d r%0d", i, s), obs_data[i*16 +: 16], m_rf[i][s]);
        end
        for (int i = 0; i < N; i++) begin
            check(tag, $sformatf("pe%0d flag", i), 16'(cond_out[i]), 16'(m_cond[i]));
            check(tag, $sformatf("pe%0d xfer", i), 16'(d_out[i*8 +: 8]), 16'(m_d[i]));
        end
    endtask

    task automatic run(input string tag, input logic [2:0] k, ao, input logic ce,
                       input logic [1:0] sa, input logic [2:0] sb, input logic [1:0] ds,
                       input logic [1:0] am, input logic [15:0] bc);
        op_kind = k; alu_op = ao; cond_en = ce; src_a = sa; src_b = sb;
        dst = ds; addr_mode = am; bcast = bc;
        @(posedge clk);
        model_step();
        #1;
        compare_all(tag);
    endtask

    task automatic rows_rand();
        row_top = N*8'($urandom()); row_mid = N*8'($urandom()); row_bot = N*8'($urandom());
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        compare_all("R1");

        // R2/R4: load constants, exercise every ALU code
        run("R4", 3'd1, 3'd6, 0, 2'd0, 3'd5, 2'd0, 2'd0, 16'hFFF0);
        run("R4", 3'd1, 3'd6, 0, 2'd0, 3'd5, 2'd1, 2'd0, 16'h0025);
        for (int op = 0; op < 8; op++)
            run("R2", 3'(op), 3'd0, 0, 2'd0, 3'd1, 2'd2, 2'd0, 16'h0) ;
        for (int op = 0; op < 8; op++)
            run("R2", 3'd1, 3'(op), 0, 2'd0, 3'd1, 2'd2, 2'd0, 16'h0);

        // R10: fill every memory word globally, then read in each mode
        run("R10", 3'd1, 3'd6, 0, 2'd0, 3'd5, 2'd0, 2'd0, 16'h5A5A);
        for (int a = 0; a < 256; a++)
            run("R10", 3'd7, 3'd0, 0, 2'd0, 3'd0, 2'd0, 2'd0, 16'(a));
        run("R10", 3'd1, 3'd6, 0, 2'd0, 3'd5, 2'd3, 2'd0, 16'h0037);
        run("R10", 3'd7, 3'd0, 0, 2'd3, 3'd0, 2'd0, 2'd1, 16'h00A0);
        run("R10", 3'd1, 3'd6, 0, 2'd0, 3'd6, 2'd1, 2'd0, 16'h00A7);
        run("R10", 3'd1, 3'd6, 0, 2'd0, 3'd6, 2'd1, 2'd2, 16'h0000);

        // R7/R8/R9: per-element directions, including edges past the array end
        row_top = 32'h44332211; row_mid = 32'h09060200; row_bot = 32'h88776655;
        run("R7", 3'd5, 3'd0, 0, 2'd0, 3'd0, 2'd0, 2'd0, 16'h0);
        rows_rand();
        run("R7", 3'd1, 3'd6, 0, 2'd0, 3'd4, 2'd0, 2'd0, 16'h0);
        run("R8", 3'd6, 3'd0, 0, 2'd0, 3'd0, 2'd0, 2'd0, 16'h0);
        run("R9", 3'd1, 3'd6, 0, 2'd0, 3'd4, 2'd1, 2'd0, 16'h0);

        // R3: load and shift the transfer chain
        run("R3", 3'd3, 3'd0, 0, 2'd1, 3'd0, 2'd0, 2'd0, 16'h0);
        for (int s = 0; s < 4; s++) run("R3", 3'd4, 3'd0, 0, 2'd0, 3'd0, 2'd0, 2'd0, 16'h0);

        // R5/R6: flag from sign, then gated ops, then flag from zero
        run("R5", 3'd1, 3'd6, 0, 2'd0, 3'd5, 2'd0, 2'd0, 16'h8000);
        run("R5", 3'd2, 3'd0, 0, 2'd0, 3'd0, 2'd0, 2'd0, 16'h0);
        run("R5", 3'd1, 3'd6, 0, 2'd0, 3'd5, 2'd0, 2'd0, 16'h0000);
        run("R5", 3'd2, 3'd0, 0, 2'd0, 3'd0, 2'd0, 2'd0, 16'h0);
        run("R5", 3'd1, 3'd6, 0, 2'd0, 3'd5, 2'd0, 2'd0, 16'h0001);
        run("R5", 3'd2, 3'd1, 0, 2'd0, 3'd0, 2'd0, 2'd0, 16'h0);
        run("R6", 3'd1, 3'd6, 1, 2'd0, 3'd5, 2'd1, 2'd0, 16'h1234);
        run("R6", 3'd3, 3'd0, 1, 2'd1, 3'd0, 2'd0, 2'd0, 16'h0);
        run("R6", 3'd4, 3'd0, 1, 2'd0, 3'd0, 2'd0, 2'd0, 16'h0);
        run("R11", 3'd1, 3'd6, 0, 2'd0, 3'd5, 2'd1, 2'd0, 16'h4321);
        run("R11", 3'd0, 3'd6, 0, 2'd0, 3'd5, 2'd1, 2'd0, 16'h9999);

        // random mix covering R2..R11
        for (int n = 0; n < 1500; n++) begin
            rows_rand();
            run("R2-mix", 3'($urandom()), 3'($urandom()), 1'($urandom()), 2'($urandom()),
                3'($urandom()), 2'($urandom()), 2'($urandom()), 16'($urandom()));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule